// File: doc/BRIEF.md
# Ripple Chain Multi-Modulus Divider

This block divides a fast input clock by any whole number from 128 to 159. A 5-bit selection word picks the ratio in steps of one. Inside, five dual-modulus stages sit in a chain. The four fastest stages each divide by two or by three. The slowest stage divides by eight or by nine.

Each stage normally takes its shortest count. A stage stretches its count by one input tick only when two things are true: its own selection bit is set, and the next slower stage is in the final tick of its own count while that stage is itself enabled to stretch. As a result, every fast stage is stretched at most once per full output period. This gives one output period of 16·(8 + S4) + 8·S3 + 4·S2 + 2·S1 + S0 input cycles. S0 steers the fastest stage and S4 steers the slowest.

The model is cycle-accurate and uses a single clock domain. Stages advance on enables derived from the input clock, so no stage makes a clock of its own. The selection word is captured once per output period, on the same edge that starts the new period. The modulus-out signal of every stage is brought out for observation.

Top module: `rmd_divider`

## Requirements
- R1: The number of input clock cycles between successive rising edges of `clk_div` equals 128 + S. S is `div_sel` read as an unsigned number, with bit 0 weighted 1 and bit 4 weighted 16.
- R2: The two extremes work. S = 0 gives exactly 128 input cycles per output period, and S = 31 gives exactly 159.
- R3: `div_sel` is captured only on the input clock edge at which `clk_div` rises. A change made in the middle of a period leaves that period's length unchanged and sets the length of the next period.
- R4: While `rst_n` is low at a clock edge, `clk_div` and every bit of `stage_mod` are 0 after that edge. After release, the first rising edge of `clk_div` comes exactly 128 + S input edges after the last reset edge, with S as it was at that reset edge.
- R5: Once a rising edge has been seen, `clk_div` stays high for exactly 64 input cycles in each period, whatever the ratio.
- R6: `stage_mod[0]` (the fastest stage's modulus-out) is high for exactly one input cycle per output period. That cycle is the one just before `clk_div` rises.
- R7: `stage_mod[4]` (the slowest stage's modulus-out) is high for exactly 16 + (S mod 16) input cycles per output period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Fast input clock to be divided |
| rst_n | input | 1 | Synchronous active-low reset |
| div_sel | input | 5 | Division selection S; ratio is 128 + S |
| clk_div | output | 1 | Divided output clock |
| stage_mod | output | 5 | Modulus-out of each stage; bit 0 is the fastest stage |

## Verification
Two things can fall on the same input edge: the divider reaches the end of a period and loads a new selection word, and the bench changes `div_sel`. To provoke this, the selection word is changed at random offsets and also directly in the middle of a period. Every length is judged against the word that was present on the edge just before each rising edge, and periods that saw a mid-period change are reported under R3. Resetting while a period is running checks that the first period after release starts clean.

// File: rtl/rmd_pkg.sv
// Shared helpers for the multi-modulus divider.
// Assumes the stage counts are small positive integers.
package rmd_pkg;

    // Number of bits needed to hold values 0..v.
    function automatic int unsigned bits_for(input int unsigned v);
        return (v < 2) ? 1 : $clog2(v + 1);
    endfunction

    // Smallest ratio of a chain: base of the last stage scaled by 2^(n-1).
    function automatic int unsigned min_ratio(input int unsigned stages, input int unsigned last_base);
        return last_base << (stages - 1);
    endfunction

endpackage

// File: rtl/rmd_cell.sv
// One dual-modulus counting stage of the divider.
// It advances only on cycles where its step enable is high. It returns to
// zero when the parent says the current count is the final one. The
// stretch decision (BASE or BASE+1) is made outside, from this stage's phase.
module rmd_cell #(
    parameter int unsigned BASE  = 2,
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             at_end,
    output logic [CNT_W-1:0] phase
);

    // Phase counter: clear on reset, advance or wrap on each step.
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase <= '0;
        else if (step)
            phase <= at_end ? '0 : phase + 1'b1;
    end

    // R1: a stage never counts past its stretched length.
    a_r1_phase_bound: assert property (@(posedge clk) disable iff (!rst_n)
        phase <= CNT_W'(BASE));

endmodule

// File: rtl/rmd_ctrl_hold.sv
// Holds the division selection for a whole output period.
// Loads during reset and on the cycle that ends a period, and keeps its value otherwise.
module rmd_ctrl_hold #(
    parameter int unsigned W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] sel_in,
    output logic [W-1:0] sel_q
);

    // Capture the selection at reset or at a period boundary.
    always_ff @(posedge clk) begin
        if (!rst_n || load)
            sel_q <= sel_in;
    end

    // R3: between boundaries the held selection does not move.
    a_r3_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(sel_q));

    // R3: at a boundary the held selection takes the input of that edge.
    a_r3_load_value: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> sel_q == $past(sel_in));

endmodule

// File: rtl/rmd_out_shape.sv
// Builds the divided clock from the slowest stage.
// High from the start of a period until the slowest stage reaches FALL_AT.
// Assumes FALL_AT is less than the slowest stage's shortest count.
module rmd_out_shape #(
    parameter int unsigned CNT_W   = 4,
    parameter int unsigned FALL_AT = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wrap,
    input  logic             step_last,
    input  logic [CNT_W-1:0] phase_last,
    output logic             clk_div
);

    // Output register: set at period start, cleared at the midpoint of the slowest stage.
    always_ff @(posedge clk) begin
        if (!rst_n)
            clk_div <= 1'b0;
        else if (wrap)
            clk_div <= 1'b1;
        else if (step_last && phase_last == CNT_W'(FALL_AT - 1))
            clk_div <= 1'b0;
    end

    // R1: a rising output edge always follows a period wrap.
    a_r1_rise_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_div) |-> $past(wrap));

endmodule

// File: rtl/rmd_divider.sv
// Multi-modulus divider: NUM_STAGES-1 divide-by-2/3 stages followed by a
// divide-by-LAST_BASE/LAST_BASE+1 stage. Ratio = LAST_BASE*2^(n-1) + div_sel.
// All stages run on clk_in with enables; the stretch and modulus chain is
// worked out in one combinational block, from the slowest stage to the fastest.
module rmd_divider #(
    parameter int unsigned NUM_STAGES = 5,
    parameter int unsigned LAST_BASE  = 8
) (
    input  logic                  clk_in,
    input  logic                  rst_n,
    input  logic [NUM_STAGES-1:0] div_sel,
    output logic                  clk_div,
    output logic [NUM_STAGES-1:0] stage_mod
);
    import rmd_pkg::*;

    localparam int unsigned CNT_W     = bits_for(LAST_BASE);
    localparam int unsigned RATIO_MIN = min_ratio(NUM_STAGES, LAST_BASE);
    localparam int unsigned PER_W     = bits_for(RATIO_MIN * 2);

    logic [NUM_STAGES-1:0] sel_q;
    logic [NUM_STAGES-1:0] step;
    logic [NUM_STAGES-1:0] last;
    logic [CNT_W-1:0]      phase [NUM_STAGES];
    logic                  wrap;

    // Modulus chain (slow to fast), then enable chain (fast to slow).
    always_comb begin
        logic        m;
        logic        e;
        logic        ext;
        int unsigned base;
        m = 1'b1;
        for (int i = NUM_STAGES - 1; i >= 0; i--) begin
            base         = (i == NUM_STAGES - 1) ? LAST_BASE : 2;
            ext          = m & sel_q[i];
            last[i]      = (phase[i] == CNT_W'(base - 1 + int'(ext)));
            stage_mod[i] = m & last[i];
            m            = stage_mod[i];
        end
        e = 1'b1;
        for (int i = 0; i < NUM_STAGES; i++) begin
            step[i] = e;
            e       = e & last[i];
        end
        wrap = e;
    end

    rmd_ctrl_hold #(.W(NUM_STAGES)) u_hold (
        .clk    (clk_in),
        .rst_n  (rst_n),
        .load   (wrap),
        .sel_in (div_sel),
        .sel_q  (sel_q)
    );

    for (genvar g = 0; g < NUM_STAGES; g++) begin : g_stage
        rmd_cell #(
            .BASE  ((g == NUM_STAGES - 1) ? LAST_BASE : 2),
            .CNT_W (CNT_W)
        ) u_cell (
            .clk    (clk_in),
            .rst_n  (rst_n),
            .step   (step[g]),
            .at_end (last[g]),
            .phase  (phase[g])
        );
    end

    rmd_out_shape #(.CNT_W(CNT_W), .FALL_AT(LAST_BASE / 2)) u_shape (
        .clk        (clk_in),
        .rst_n      (rst_n),
        .wrap       (wrap),
        .step_last  (step[NUM_STAGES-1]),
        .phase_last (phase[NUM_STAGES-1]),
        .clk_div    (clk_div)
    );

    // Checker counter: input cycles since the start of the current period.
    logic [PER_W-1:0] per_cnt;
    always_ff @(posedge clk_in) begin
        if (!rst_n || wrap)
            per_cnt <= '0;
        else
            per_cnt <= per_cnt + 1'b1;
    end

    // R1: each period lasts exactly RATIO_MIN plus the held selection.
    a_r1_ratio: assert property (@(posedge clk_in) disable iff (!rst_n)
        wrap |-> (int'(per_cnt) + 1 == int'(RATIO_MIN) + int'(sel_q)));

    // R6: the fastest modulus-out is high in the cycle before each output rise.
    a_r6_mod_before_rise: assert property (@(posedge clk_in) disable iff (!rst_n)
        $rose(clk_div) |-> $past(stage_mod[0]));

endmodule

// File: tb/sim_rmd_divider.sv
// Self-checking bench for rmd_divider: a directed sweep, random selection
// changes at random offsets, reset in the middle of a run and a directed mid-period change.
module sim_rmd_divider;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rst_q = 1'b0;
    logic [4:0] sel = 5'd0;
    logic       clk_div;
    logic [4:0] stage_mod;

    int checks = 0;
    int fails  = 0;
    int rises  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    rmd_divider u0 (
        .clk_in    (clk),
        .rst_n     (rst_n),
        .div_sel   (sel),
        .clk_div   (clk_div),
        .stage_mod (stage_mod)
    );

    function automatic int exp_ratio(input int s);
        return 128 + s;
    endfunction

    function automatic int exp_mod4(input int s);
        return 16 + (s % 16);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    // Reset value as seen by the most recent clock edge.
    always @(posedge clk) rst_q <= rst_n;

    // Period monitor, sampled on the falling edge.
    int    cnt = 0, hi = 0, m0 = 0, m4 = 0, per_c = 0, prev_c = 0;
    bit    first = 1'b1, chg = 1'b0, prev_out = 1'b0, last_m0 = 1'b0;
    string lbl;
    always @(negedge clk) begin
        if (!rst_q) begin
            cnt = 0; hi = 0; m0 = 0; m4 = 0;
            first = 1'b1; chg = 1'b0; prev_out = 1'b0; last_m0 = 1'b0;
            per_c = prev_c;
        end else begin
            cnt++;
            m0 += int'(stage_mod[0]);
            m4 += int'(stage_mod[4]);
            if (clk_div && !prev_out) begin
                if (chg)                          lbl = "R3";
                else if (per_c == 0 || per_c == 31) lbl = "R2";
                else if (first)                   lbl = "R4";
                else                              lbl = "R1";
                check(cnt == exp_ratio(per_c), lbl, cnt, exp_ratio(per_c));
                check(m0 == 1 && last_m0, "R6", m0, 1);
                check(m4 == exp_mod4(per_c), "R7", m4, exp_mod4(per_c));
                if (!first) check(hi == 64, "R5", hi, 64);
                first = 1'b0; chg = 1'b0;
                hi = 1; cnt = 0; m0 = 0; m4 = 0;
                per_c = prev_c;
                rises++;
            end else begin
                hi += int'(clk_div);
            end
            if (int'(sel) != per_c) chg = 1'b1;
            last_m0  = stage_mod[0];
            prev_out = clk_div;
        end
        prev_c = int'(sel);
    end

    task automatic wait_rises(input int n);
        int target;
        target = rises + n;
        while (rises < target) @(negedge clk);
    endtask

    task automatic set_sel(input int v);
        @(posedge clk);
        #1 sel = 5'(v);
    endtask

    task automatic do_reset(input int v);
        @(posedge clk);
        #1 rst_n = 1'b0;
        sel = 5'(v);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(clk_div == 1'b0, "R4", int'(clk_div), 0);
        check(stage_mod == 5'd0, "R4", int'(stage_mod), 0);
        @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        do_reset(0);
        wait_rises(2);
        // Directed sweep of every selection value (R1, R2).
        for (int s = 0; s < 32; s++) begin
            set_sel(s);
            wait_rises(2);
        end
        // Random selections at random offsets (R3 when mid-period).
        for (int k = 0; k < 30; k++) begin
            set_sel(int'($urandom % 32));
            repeat (int'($urandom % 300)) @(posedge clk);
        end
        wait_rises(2);
        // Reset in the middle of a period with the top ratio (R4).
        repeat (50) @(posedge clk);
        do_reset(31);
        wait_rises(2);
        // Directed mid-period change 0 -> 31 (R3).
        set_sel(0);
        wait_rises(2);
        repeat (40) @(posedge clk);
        #1 sel = 5'd31;
        wait_rises(3);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule